// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Port

This block controls one port of up to eight general-purpose pins through a plain register read/write bus. Every pin has its own 32-byte register window. The window holds a configuration word, a debounce threshold, the sampled input, a float control for the output driver, the driven output level and an interrupt acknowledge. A pin can drive its pad as an output or observe it as an input. On input, the pad passes through a two-flop synchronizer and then an optional debouncer that counts millisecond ticks from an external prescaler enable.

Each pin can raise an interrupt on a level, on a single edge or on both edges. A polarity bit selects high/rising or low/falling. Edge events latch until software acknowledges them. Level events follow the qualified pin level. A status word collects one bit per pin, and the pins whose interrupt enable is set drive the single port interrupt line.

Reads return data combinationally in the same cycle as the address. Writes take effect at the clock edge where `wr_en` is high.

Top module: `pinbank_ctl`

## Requirements
- R1: After reset, every configuration word reads 0, every debounce threshold reads 0, every float bit reads 1, every output value reads 0, the status word reads 0, `irq` is low and `pad_oe` is all zero.
- R2: Pin p's window starts at byte address p*0x20. Within the window, configuration is at +0x00, threshold at +0x04, input at +0x08, float control at +0x0C, output value at +0x10 and acknowledge at +0x14. The configuration fields are: bit 0 pin enable, bit 1 output direction, bits 3:2 trigger type, bit 4 polarity, bit 5 debounce enable and bit 6 interrupt enable. `pad_oe[p]` is high exactly when the pin is enabled, its direction is output and float bit 0 is clear. `pad_out[p]` equals output-value bit 0.
- R3: The input register (bit 0) returns the driven output value when configuration bit 1 is set. Otherwise it returns the qualified pad level.
- R4: When debounce is disabled (bit 5 clear) or the threshold is 0, the qualified level is the pad seen through two flops: a pad change driven between edges reads back after exactly two rising clock edges.
- R5: With debounce enabled and a nonzero 8-bit threshold N, a new synchronized level is taken only after it has differed from the qualified level across N `tick_ms` pulses without a break. A change that reverts earlier leaves the qualified level unchanged.
- R6: Trigger type 01 (level): the status bit equals (qualified level == polarity bit) while the pin is enabled. An acknowledge write has no lasting effect while that condition holds.
- R7: Trigger type 10 (single edge): a rising edge (polarity 1) or falling edge (polarity 0) of the qualified level sets a latched status bit. The bit stays set until 1 is written to bit 0 of the acknowledge register.
- R8: Trigger type 11 (both edges): any edge of the qualified level sets the latched status bit, whatever the polarity bit.
- R9: With interrupt enable (bit 6) clear, the pin's status bit is still recorded but does not drive `irq`. Setting the enable later raises `irq` from the status that is already pending.
- R10: The status word at byte address 0x100 holds bit p for pin p. `irq` is high exactly when some status bit with its enable set is high. Trigger type 00 never sets status. Unused register bits read as zero and the acknowledge register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond for the debouncers |
| wr_en | input | 1 | Write strobe |
| addr | input | 9 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 8 | Pad levels seen by each pin |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Output driver enable per pad |
| irq | output | 1 | Port interrupt line |

## Verification
The bench samples the exact cycle in which a bypassed pin's level appears after the two synchronizer flops, so a design with one flop too many or too few shows up. It stops the debouncer one tick short of its threshold and also breaks a change before the threshold is reached, which catches a counter that does not reset on a glitch or that accepts a level one tick early. It acknowledges a level-triggered pin while the level is still active, sets an edge pin's polarity the wrong way, and uses both-edge mode with polarity set. A design that latched levels, ignored polarity, or let polarity filter both-edge mode would then report the wrong status. Random toggling over a mix of trigger types and masks, with acknowledges scattered in, checks that a masked pin still records status and that stale latches do not leak onto `irq`.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'b00,
        TRIG_LEVEL = 2'b01,
        TRIG_EDGE  = 2'b10,
        TRIG_ANY   = 2'b11
    } trig_e;

    // packed MSB first: bit6 irq_en .. bit0 en
    typedef struct packed {
        logic  irq_en;
        logic  deb_en;
        logic  pol_hi;
        trig_e trig;
        logic  dir_out;
        logic  en;
    } pin_cfg_t;

    localparam int CFG_W    = 7;
    localparam int WIN_BITS = 5;
    localparam logic [WIN_BITS-1:0] OFS_CFG = 5'h00;
    localparam logic [WIN_BITS-1:0] OFS_DEB = 5'h04;
    localparam logic [WIN_BITS-1:0] OFS_IN  = 5'h08;
    localparam logic [WIN_BITS-1:0] OFS_FLT = 5'h0C;
    localparam logic [WIN_BITS-1:0] OFS_OUT = 5'h10;
    localparam logic [WIN_BITS-1:0] OFS_ACK = 5'h14;

    function automatic logic level_match(input logic lvl, input logic pol);
        return lvl == pol;
    endfunction

endpackage

// File: rtl/pin_filter.sv
module pin_filter #(
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           pad,
    input  logic           bypass,
    input  logic [DBW-1:0] thr,
    output logic           level
);
    localparam logic [DBW-1:0] STEP = 1;

    logic           s1, s2, held;
    logic [DBW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            held <= 1'b0;
            cnt  <= '0;
        end else begin
            s1 <= pad;
            s2 <= s1;
            if (bypass) begin
                held <= s2;
                cnt  <= '0;
            end else if (s2 == held) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt + STEP == thr) begin
                    held <= s2;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + STEP;
                end
            end
        end
    end

    assign level = bypass ? s2 : held;
endmodule

// File: rtl/pin_trigger.sv
module pin_trigger
    import pinbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    input  pin_cfg_t cfg,
    input  logic     ack,
    output logic     stat,
    output logic     latch
);
    logic prev, rise, fall, hit;
    logic edge_mode;

    assign rise      = level & ~prev;
    assign fall      = ~level & prev;
    assign edge_mode = (cfg.trig == TRIG_EDGE) || (cfg.trig == TRIG_ANY);

    always_comb begin
        unique case (cfg.trig)
            TRIG_EDGE: hit = cfg.pol_hi ? rise : fall;
            TRIG_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        hit = hit & cfg.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            latch <= 1'b0;
        end else begin
            prev <= level;
            if (!edge_mode)  latch <= 1'b0;
            else if (hit)    latch <= 1'b1;
            else if (ack)    latch <= 1'b0;
        end
    end

    assign stat = (cfg.trig == TRIG_LEVEL) ? (cfg.en & level_match(level, cfg.pol_hi))
                                           : latch;
endmodule

// File: rtl/pin_cell.sv
module pin_cell
    import pinbank_pkg::*;
#(
    parameter int DBW = 8,
    parameter int DW  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                pad,
    input  logic                sel,
    input  logic                wr,
    input  logic [WIN_BITS-1:0] ofs,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rd,
    output logic                stat,
    output logic                latch,
    output logic                irq_en,
    output logic                drv,
    output logic                oe
);
    pin_cfg_t       cfg;
    logic [DBW-1:0] thr;
    logic           flt, outv, level, ack, bypass;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            thr  <= '0;
            flt  <= 1'b1;
            outv <= 1'b0;
        end else if (wr && sel) begin
            case (ofs)
                OFS_CFG: cfg  <= pin_cfg_t'(wdata[CFG_W-1:0]);
                OFS_DEB: thr  <= wdata[DBW-1:0];
                OFS_FLT: flt  <= wdata[0];
                OFS_OUT: outv <= wdata[0];
                default: ;
            endcase
        end
    end

    assign ack    = wr && sel && (ofs == OFS_ACK) && wdata[0];
    assign bypass = !cfg.deb_en || (thr == '0);

    pin_filter #(.DBW(DBW)) u_filt (
        .clk(clk), .rst(rst), .tick(tick), .pad(pad),
        .bypass(bypass), .thr(thr), .level(level)
    );

    pin_trigger u_trig (
        .clk(clk), .rst(rst), .level(level), .cfg(cfg),
        .ack(ack), .stat(stat), .latch(latch)
    );

    always_comb begin
        rd = '0;
        case (ofs)
            OFS_CFG: rd[CFG_W-1:0] = cfg;
            OFS_DEB: rd[DBW-1:0]   = thr;
            OFS_IN:  rd[0]         = cfg.dir_out ? outv : level;
            OFS_FLT: rd[0]         = flt;
            OFS_OUT: rd[0]         = outv;
            default: ;
        endcase
    end

    assign irq_en = cfg.irq_en;
    assign drv    = outv;
    assign oe     = cfg.en & cfg.dir_out & ~flt;
endmodule

// File: rtl/pinbank_ctl.sv
module pinbank_ctl
    import pinbank_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DBW   = 8,
    parameter int AW    = 9,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq
);
    localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1;
    localparam logic [AW-1:0] STAT_ADDR = AW'(256);

    logic [NPINS-1:0] stat_vec, latch_vec, ien_vec;
    logic [DW-1:0]    cell_rd [NPINS];
    logic [PW-1:0]    pin_idx;
    logic             win_hit;

    assign pin_idx = addr[WIN_BITS +: PW];
    assign win_hit = (addr[AW-1] == 1'b0);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cell #(.DBW(DBW), .DW(DW)) u_cell (
            .clk(clk), .rst(rst), .tick(tick_ms), .pad(pad_in[i]),
            .sel(win_hit && (pin_idx == PW'(i))), .wr(wr_en),
            .ofs(addr[WIN_BITS-1:0]), .wdata(wdata), .rd(cell_rd[i]),
            .stat(stat_vec[i]), .latch(latch_vec[i]), .irq_en(ien_vec[i]),
            .drv(pad_out[i]), .oe(pad_oe[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == STAT_ADDR) begin
            rdata[NPINS-1:0] = stat_vec;
        end else if (win_hit) begin
            for (int i = 0; i < NPINS; i++)
                if (pin_idx == PW'(i)) rdata = cell_rd[i];
        end
    end

    assign irq = |(stat_vec & ien_vec);
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int NPINS = 8,
    parameter int AW    = 9,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    rdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] stat_vec,
    input logic [NPINS-1:0] latch_vec,
    input logic             irq
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_oe == '0));

    p_oe_only_by_write_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(pad_oe));

    p_drive_only_by_write_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(pad_out));

    p_latch_kept_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ((latch_vec & $past(latch_vec)) == $past(latch_vec)));

    p_irq_has_status_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_vec != '0));

    p_status_upper_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (addr == AW'(256)) |-> (rdata[DW-1:NPINS] == '0));
endmodule

bind pinbank_ctl pinbank_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .stat_vec(stat_vec),
    .latch_vec(latch_vec), .irq(irq)
);

// File: tb/sim_pinbank_ctl.sv
module sim_pinbank_ctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] STAT = 9'h100;

    logic        clk = 0, rst = 1, tick_ms = 0, wr_en = 0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [7:0]  pad_in = '0, pad_out, pad_oe;
    logic        irq;
    int          n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_ctl u0 (.clk(clk), .rst(rst), .tick_ms(tick_ms), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); tick_ms = 1;
        @(negedge clk); tick_ms = 0;
    endtask

    function automatic logic [8:0] pa(input int p, input int ofs);
        return 9'(p * 32 + ofs);
    endfunction

    function automatic logic exp_stat(input int t, input logic pol, input logic lvl, input logic lat);
        if (t == 1) return lvl == pol;
        if (t >= 2) return lat;
        return 1'b0;
    endfunction

    task automatic stat_bit(input int p, output logic b);
        logic [31:0] d;
        rd(STAT, d); b = d[p];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        b;
        int          typ [8];
        logic        pol [8], ien [8], lvl [8], lat [8];
        cyc(3); rst = 0; cyc(1);

        // R1 reset state
        rd(pa(0, 0), d);    check("R1 cfg", d, 0);
        rd(pa(3, 4), d);    check("R1 thr", d, 0);
        rd(pa(3, 12), d);   check("R1 float", d, 1);
        rd(pa(5, 16), d);   check("R1 outv", d, 0);
        rd(STAT, d);        check("R1 status", d, 0);
        check("R1 irq/oe", {23'b0, irq, pad_oe}, 0);

        // R2 / R3 output path on pin 2
        wr(pa(2, 16), 1); wr(pa(2, 0), 32'h03);
        check("R2 oe held by float", pad_oe, 0);
        wr(pa(2, 12), 0);
        check("R2 oe", pad_oe, 8'h04);
        check("R2 pad_out", pad_out, 8'h04);
        rd(pa(2, 8), d);    check("R3 input shows driven 1", d, 1);
        wr(pa(2, 16), 0);
        rd(pa(2, 8), d);    check("R3 input shows driven 0", d, 0);
        check("R2 pad_out low", pad_out, 0);

        // R4 sync latency, bypass
        wr(pa(1, 0), 32'h01);
        pad_in[1] = 1;
        cyc(1); rd(pa(1, 8), d); check("R4 after one edge", d, 0);
        cyc(1); rd(pa(1, 8), d); check("R4 after two edges", d, 1);
        rd(pa(1, 8), d); check("R3 input mode reads pad", d, 1);

        // R5 debounce on pin 4, threshold 3
        wr(pa(4, 4), 32'hFFFF_FF03); wr(pa(4, 0), 32'h21);
        rd(pa(4, 4), d); check("R10 thr upper bits zero", d, 3);
        pad_in[4] = 1; cyc(4);
        tick(); tick();
        rd(pa(4, 8), d); check("R5 two ticks not enough", d, 0);
        tick();
        rd(pa(4, 8), d); check("R5 third tick accepts", d, 1);
        pad_in[4] = 0; cyc(4); tick(); tick();
        pad_in[4] = 1; cyc(4); tick(); tick(); tick();
        rd(pa(4, 8), d); check("R5 glitch rejected", d, 1);
        wr(pa(4, 4), 0); pad_in[4] = 0; cyc(3);
        rd(pa(4, 8), d); check("R4 zero threshold bypass", d, 0);

        // R6 level trigger on pin 5
        wr(pa(5, 0), 32'h55); cyc(2);
        stat_bit(5, b); check("R6 low level, pol high", b, 0);
        pad_in[5] = 1; cyc(4);
        stat_bit(5, b); check("R6 high level", b, 1);
        check("R10 irq from level", irq, 1);
        wr(pa(5, 20), 1);
        stat_bit(5, b); check("R6 ack ignored while active", b, 1);
        pad_in[5] = 0; cyc(4);
        stat_bit(5, b); check("R6 follows level", b, 0);
        check("R10 irq drops", irq, 0);
        wr(pa(5, 0), 32'h45); cyc(1);
        stat_bit(5, b); check("R6 low polarity", b, 1);
        wr(pa(5, 0), 32'h01);

        // R7 single edge on pin 6
        wr(pa(6, 0), 32'h59);
        pad_in[6] = 1; cyc(4);
        stat_bit(6, b); check("R7 rising latched", b, 1);
        pad_in[6] = 0; cyc(4);
        stat_bit(6, b); check("R7 holds after level drops", b, 1);
        wr(pa(6, 20), 1);
        stat_bit(6, b); check("R7 ack clears", b, 0);
        check("R7 irq after ack", irq, 0);
        wr(pa(6, 0), 32'h49);
        pad_in[6] = 1; cyc(4);
        stat_bit(6, b); check("R7 falling mode ignores rise", b, 0);
        pad_in[6] = 0; cyc(4);
        stat_bit(6, b); check("R7 falling latched", b, 1);
        wr(pa(6, 20), 1);

        // R8 both edges with polarity set
        wr(pa(6, 0), 32'h5D);
        pad_in[6] = 1; cyc(4);
        stat_bit(6, b); check("R8 rise", b, 1);
        wr(pa(6, 20), 1);
        pad_in[6] = 0; cyc(4);
        stat_bit(6, b); check("R8 fall despite polarity", b, 1);
        wr(pa(6, 20), 1); wr(pa(6, 0), 32'h01);

        // R9 masked pin 7
        wr(pa(7, 0), 32'h19);
        pad_in[7] = 1; cyc(4);
        stat_bit(7, b); check("R9 status recorded while masked", b, 1);
        check("R9 irq masked", irq, 0);
        wr(pa(7, 0), 32'h59);
        check("R9 unmask raises irq", irq, 1);
        wr(pa(7, 20), 1);
        check("R9 irq after ack", irq, 0);

        // R10 type off and unused bits
        wr(pa(7, 0), 32'h51);
        pad_in[7] = 0; cyc(4);
        stat_bit(7, b); check("R10 type off no status", b, 0);
        wr(pa(0, 0), 32'hFFFF_FFFF);
        rd(pa(0, 0), d); check("R10 cfg unused bits", d, 32'h7F);
        rd(pa(0, 20), d); check("R10 ack reads zero", d, 0);
        wr(pa(0, 0), 0);

        // random phase
        @(negedge clk); rst = 1; pad_in = '0; cyc(2); rst = 0; cyc(1);
        void'($urandom(32'h5EED));
        for (int p = 0; p < 8; p++) begin
            typ[p] = int'($urandom % 4); pol[p] = 1'($urandom); ien[p] = 1'($urandom);
            lvl[p] = 0; lat[p] = 0;
            wr(pa(p, 0), 32'(1 | (typ[p] << 2)) | {25'b0, ien[p], 1'b0, pol[p], 4'b0});
        end
        for (int it = 0; it < 150; it++) begin
            int          p = int'($urandom % 8);
            logic        nl = 1'($urandom);
            logic [7:0]  es;
            logic        ei;
            if (nl != lvl[p]) begin
                if (typ[p] == 3 || (typ[p] == 2 && nl == pol[p])) lat[p] = 1;
                pad_in[p] = nl; lvl[p] = nl;
            end
            cyc(4);
            if ($urandom % 4 == 0) begin
                wr(pa(p, 20), 1); lat[p] = 0;
            end
            ei = 0;
            for (int q = 0; q < 8; q++) begin
                es[q] = exp_stat(typ[q], pol[q], lvl[q], lat[q]);
                ei = ei | (es[q] & ien[q]);
            end
            rd(STAT, d);
            check("R10 random status", d, {24'b0, es});
            check("R9 random irq", irq, ei);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule